// File: doc/BRIEF.md
# Preset Binary Frequency Divider

This block divides its clock by a ratio chosen at run time. It is a 16-bit up-counter built from four identical 4-bit synchronous stages that share one clock. Each stage steps only when every stage below it reads 0xF. When the whole counter reaches 0xFFFF, the next edge reloads the preset value from `preload_i`. One period therefore spans `65536 - preload_i` clocks.

The block drives `div_o` high for exactly one clock per period, during the terminal-count cycle. For example, a preset of 0x63C0 divides the clock by 40,000. After an active-low asynchronous reset, the first clock edge loads the preset. Counting starts from that value.

Top module: `preset_divider`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0x0000 and `div_o` is 0.
- R2: The first rising edge after reset release loads `preload_i` into `count_o`. During the cycle before that edge, `div_o` stays 0.
- R3: In every other cycle the count rises by exactly one. A 4-bit stage (bits 4k+3..4k, stage 0 is the LSB nibble) advances only when all lower stages hold 0xF. For example, 0x0FFE goes to 0x0FFF and then to 0x1000.
- R4: `div_o` is 1 exactly in the cycles where the running counter holds 0xFFFF.
- R5: The edge that ends a cycle with `div_o` high loads the value of `preload_i` present at that edge.
- R6: With a constant preset P, the spacing between `div_o` pulses is 65536 − P clocks. A preset of 0x63C0 gives 40,000 clocks.
- R7: With preset 0xFFFF, the ratio is 1: `div_o` stays high on every cycle and `count_o` stays at 0xFFFF.
- R8: Changing `preload_i` in the middle of a period does not alter the current count sequence. The new value takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by all stages |
| rst_ni | input | 1 | Asynchronous reset, active low |
| preload_i | input | 16 | Preset value loaded at start and at each terminal count |
| count_o | output | 16 | Current counter value |
| div_o | output | 1 | Divided output, high for one clock at terminal count |

## Verification
The hardest situation to reach from the ports is the full 40,000-clock period: a carry has to ripple through all four stages many times before the reload can be seen. The bench uses small ratios for the reload and carry corner cases. It places a preset just below a nibble boundary (0x0FFE) so that the carry reaches three stages within two clocks. It runs the 0x63C0 case only once, measuring the distance between two consecutive pulses. A mid-period change of the preset is driven at a known count, so that the old and new ratios can be told apart.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  localparam int unsigned NIB_W_DEF  = 4;
  localparam int unsigned NIB_CNT_DEF = 4;

  typedef enum logic {
    ST_PRIME = 1'b0,
    ST_RUN   = 1'b1
  } run_e;
endpackage

// File: rtl/pdiv_stage.sv
module pdiv_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o,
  output logic         rco_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_q <= '0;
    else if (load_i)   q_q <= data_i;
    else if (cnt_en_i) q_q <= q_q + W'(1);
  end

  assign q_o   = q_q;
  assign rco_o = cnt_en_i & (&q_q);
endmodule

// File: rtl/pdiv_chain.sv
module pdiv_chain #(
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned NIB_CNT = 4,
  localparam int unsigned CNT_W  = NIB_W * NIB_CNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] q_o,
  output logic             tc_o
);
  logic [NIB_CNT:0] en;

  assign en[0] = cnt_en_i;

  for (genvar k = 0; k < NIB_CNT; k++) begin : g_stage
    pdiv_stage #(.W(NIB_W)) u_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cnt_en_i (en[k]),
      .load_i   (load_i),
      .data_i   (data_i[k*NIB_W +: NIB_W]),
      .q_o      (q_o[k*NIB_W +: NIB_W]),
      .rco_o    (en[k+1])
    );
  end

  assign tc_o = en[NIB_CNT];
endmodule

// File: rtl/pdiv_ctrl.sv
module pdiv_ctrl
  import pdiv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tc_i,
  output logic run_o,
  output logic load_o
);
  run_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_PRIME;
    else         st_q <= ST_RUN;
  end

  assign run_o  = (st_q == ST_RUN);
  // prime load after reset, then reload on terminal count
  assign load_o = !run_o || tc_i;
endmodule

// File: rtl/preset_divider.sv
module preset_divider #(
  parameter int unsigned NIB_W   = pdiv_pkg::NIB_W_DEF,
  parameter int unsigned NIB_CNT = pdiv_pkg::NIB_CNT_DEF,
  localparam int unsigned CNT_W  = NIB_W * NIB_CNT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] preload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             div_o
);
  logic ctrl_run;
  logic ctrl_load;
  logic chain_tc;

  pdiv_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tc_i   (chain_tc),
    .run_o  (ctrl_run),
    .load_o (ctrl_load)
  );

  pdiv_chain #(.NIB_W(NIB_W), .NIB_CNT(NIB_CNT)) u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_en_i (ctrl_run),
    .load_i   (ctrl_load),
    .data_i   (preload_i),
    .q_o      (count_o),
    .tc_o     (chain_tc)
  );

  assign div_o = chain_tc;
endmodule

// File: rtl/pdiv_chk.sv
module pdiv_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] preload_i,
  input logic [CNT_W-1:0] count_o,
  input logic             div_o,
  input logic             run_i
);
  localparam logic [CNT_W-1:0] MAX = '1;

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (count_o == '0 && !div_o);
    end
  end

  // R2
  prime_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !div_o ##1 (run_i && count_o == $past(preload_i)));

  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !div_o) |=> count_o == $past(count_o) + CNT_W'(1));

  // R4
  tc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o == (run_i && count_o == MAX));

  // R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> count_o == $past(preload_i));
endmodule

bind preset_divider pdiv_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .preload_i (preload_i),
  .count_o   (count_o),
  .div_o     (div_o),
  .run_i     (ctrl_run)
);

// File: tb/sim_preset_divider.sv
module sim_preset_divider;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] preload_i = 16'h0000;
  logic [15:0] count_o;
  logic        div_o;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  preset_divider u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .preload_i (preload_i),
    .count_o   (count_o),
    .div_o     (div_o)
  );

  // {preset, expected period}
  localparam logic [31:0] VEC [6] = '{
    {16'hFFFF, 16'd1},
    {16'hFFFE, 16'd2},
    {16'hFFF0, 16'd16},
    {16'hFF00, 16'd256},
    {16'hF000, 16'd4096},
    {16'h63C0, 16'd40000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] pre);
    @(negedge clk);
    rst_ni = 1'b0;
    preload_i = pre;
    @(negedge clk);
    @(negedge clk);
    chk(count_o == 16'h0, "R1 count in reset", {16'h0, count_o}, 32'h0);
    chk(div_o == 1'b0, "R1 div in reset", {31'h0, div_o}, 32'h0);
    rst_ni = 1'b1;
    chk(div_o == 1'b0, "R2 no pulse before prime", {31'h0, div_o}, 32'h0);
    @(negedge clk);
    chk(count_o == pre, "R2 prime load", {16'h0, count_o}, {16'h0, pre});
  endtask

  task automatic wait_pulse(output int waited);
    waited = 0;
    while (!div_o && waited < 70000) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic measure(input logic [15:0] pre, output int n);
    int w;
    wait_pulse(w);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) chk(count_o == pre, "R5 reload value", {16'h0, count_o}, {16'h0, pre});
    end while (!div_o && n < 70000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n;
    int w;

    // R6 period table walk
    for (int i = 0; i < 6; i++) begin
      do_reset(VEC[i][31:16]);
      measure(VEC[i][31:16], n);
      chk(n == int'(VEC[i][15:0]), "R6 period", n, {16'h0, VEC[i][15:0]});
    end

    // R7 ratio one: continuous high, held at max
    do_reset(16'hFFFF);
    for (int k = 0; k < 5; k++) begin
      chk(div_o == 1'b1 && count_o == 16'hFFFF, "R7 ratio one",
          {15'h0, div_o, count_o}, {15'h0, 1'b1, 16'hFFFF});
      @(negedge clk);
    end

    // R3 carry across three stages
    do_reset(16'h0FFE);
    @(negedge clk);
    chk(count_o == 16'h0FFF, "R3 upper stages hold", {16'h0, count_o}, 32'h0FFF);
    @(negedge clk);
    chk(count_o == 16'h1000, "R3 carry ripple", {16'h0, count_o}, 32'h1000);
    chk(div_o == 1'b0, "R4 no pulse mid count", {31'h0, div_o}, 32'h0);

    // R4 pulse only at max
    do_reset(16'hFFFD);
    @(negedge clk);
    chk(div_o == 1'b0 && count_o == 16'hFFFE, "R4 below max", {15'h0, div_o, count_o}, {15'h0, 1'b0, 16'hFFFE});
    @(negedge clk);
    chk(div_o == 1'b1 && count_o == 16'hFFFF, "R4 at max", {15'h0, div_o, count_o}, {15'h0, 1'b1, 16'hFFFF});
    @(negedge clk);
    chk(div_o == 1'b0, "R4 one clock wide", {31'h0, div_o}, 32'h0);

    // R8 mid-period preset change
    do_reset(16'hFFF0);
    preload_i = 16'hFFFC;
    wait_pulse(w);
    chk(w == 15, "R8 old period kept", w, 15);
    @(negedge clk);
    chk(count_o == 16'hFFFC, "R8 new preset at reload", {16'h0, count_o}, 32'hFFFC);
    wait_pulse(w);
    chk(w == 3, "R8 new period", w, 3);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule